// File: doc/BRIEF.md
# Shadowed On/Off-Count PWM Generator

A single-channel pulse-width generator driven from a small 32-bit register interface. Software sets the length of the high phase and the length of the low phase, each as a count of clock cycles, in two count registers. A control register turns the channel on, gates the pin and selects the output polarity. Each period starts with the high phase and is followed by the low phase. With the nominal 24 MHz count clock, one count is about 41.7 ns.

Writes to the two count registers go into shadow copies only. The counter continues to use its active pair until software writes the control register with the update bit set. That write copies both shadows into the active pair in the same cycle and restarts the period, so a new period and duty take effect together and never half-applied. Every register can be read back through the same interface.

Top module: `pwm_shadow_gen`

## Requirements
- R1: After a synchronous active-low reset, all registers read zero, both active counts are zero and `pwm_out` is low.
- R2: With both active counts nonzero and the channel running, `pwm_out` is high for exactly on-count cycles and then low for exactly off-count cycles, and this repeats.
- R3: Writes to the off-count register (offset 0x18) or the on-count register (offset 0x1C) leave `pwm_out` unchanged until a control write (offset 0x00) with the update bit (bit 5) set.
- R4: A control write with bit 5 set copies both shadow counts into the active counts and starts a new period at the first cycle of the high phase.
- R5: When both active counts are zero, `pwm_out` is low whatever the polarity bit says.
- R6: When exactly one active count is zero, `pwm_out` stays constant: high if the off-count is zero, low if the on-count is zero (before polarity).
- R7: `pwm_out` is low unless control bit 0 (enable) and control bit 14 (pin enable) are both set. In particular a control value of zero holds the pin low.
- R8: While the channel is running, control bit 10 inverts the level that R2 and R6 define.
- R9: A read of offset 0x00 returns bits 0, 10 and 14 as last written, with bit 5 and all other bits zero. Reads of 0x18 and 0x1C return the last written shadow value. Reads of any other offset return zero.
- R10: Writes to offsets other than 0x00, 0x18 and 0x1C change no register and no output.
- R11: While the channel is stopped, the counter waits at the start of the high phase, so enabling the channel without an update begins a full period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count and register clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, valid in the same cycle |
| pwm_out | output | 1 | PWM pin |

## Verification
The assertions take for granted that a register access lasts one cycle, that a write and a read never target two registers at once, and that the bus is idle while reset is held. The stimulus changes bus inputs only on the falling edge and drops `bus_sel` after one cycle. Count values are kept to a few cycles so that many full periods, commits in the middle of a phase, stopped intervals and every single-zero and double-zero pair fall inside the run. A behavioural model tracks the position within the period as an integer modulo the sum of the counts and is compared with the pin on every clock.

// File: rtl/pwm_shadow_pkg.sv
// Package: shared register offsets, control bit positions and control type
// for the shadowed PWM generator. Offsets and bit positions are fixed
// because software decodes them.
package pwm_shadow_pkg;

    localparam int unsigned OFS_CTRL = 'h00;
    localparam int unsigned OFS_OFF  = 'h18;
    localparam int unsigned OFS_ON   = 'h1C;

    localparam int unsigned BIT_EN   = 0;
    localparam int unsigned BIT_UPD  = 5;
    localparam int unsigned BIT_INV  = 10;
    localparam int unsigned BIT_PEN  = 14;

    typedef struct packed {
        logic pin_en;
        logic invert;
        logic enable;
    } ctrl_t;

endpackage

// File: rtl/pwm_regfile.sv
// Module: pwm_regfile
// Register file on the bus side. Holds the control bits and the two shadow
// counts, produces a one-cycle commit strobe for a control write with the
// update bit set, and drives combinational readback.
// Assumes: one access per cycle, reads have no side effects.
module pwm_regfile
    import pwm_shadow_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  shd_on,
    output logic [CNT_W-1:0]  shd_off,
    output logic              commit
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_OFF  = ADDR_W'(OFS_OFF);
    localparam logic [ADDR_W-1:0] A_ON   = ADDR_W'(OFS_ON);

    logic wr;
    logic unused_wbits;

    assign wr           = bus_sel && bus_we;
    assign unused_wbits = ^bus_wdata;

    // Strobe that moves the shadow pair into the active pair.
    assign commit = wr && (bus_addr == A_CTRL) && bus_wdata[BIT_UPD];

    // Register writes; the update bit itself is not stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl    <= '0;
            shd_on  <= '0;
            shd_off <= '0;
        end else if (wr) begin
            case (bus_addr)
                A_CTRL: begin
                    ctrl.enable <= bus_wdata[BIT_EN];
                    ctrl.invert <= bus_wdata[BIT_INV];
                    ctrl.pin_en <= bus_wdata[BIT_PEN];
                end
                A_OFF:   shd_off <= bus_wdata[CNT_W-1:0];
                A_ON:    shd_on  <= bus_wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    // Readback multiplexer; unmapped offsets read zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: begin
                bus_rdata[BIT_EN]  = ctrl.enable;
                bus_rdata[BIT_INV] = ctrl.invert;
                bus_rdata[BIT_PEN] = ctrl.pin_en;
            end
            A_OFF:   bus_rdata = DATA_W'(shd_off);
            A_ON:    bus_rdata = DATA_W'(shd_on);
            default: bus_rdata = '0;
        endcase
    end

    // R10
    no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr != A_CTRL && bus_addr != A_OFF && bus_addr != A_ON)
        |=> ($stable(shd_on) && $stable(shd_off) && $stable(ctrl)));

endmodule

// File: rtl/pwm_phase_ctr.sv
// Module: pwm_phase_ctr
// Holds the active count pair and the phase counter. A commit loads the
// shadows and restarts at the first high cycle. The counter waits at that
// point while the channel is stopped or either count is zero.
// Assumes: commit is a single-cycle strobe.
module pwm_phase_ctr #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  logic             run,
    input  logic [CNT_W-1:0] shd_on,
    input  logic [CNT_W-1:0] shd_off,
    output logic [CNT_W-1:0] act_on,
    output logic [CNT_W-1:0] act_off,
    output logic             phase_hi
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;
    logic             hold;

    assign hold = commit || !run || (act_on == '0) || (act_off == '0);

    // Active pair loads only on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_on  <= '0;
            act_off <= '0;
        end else if (commit) begin
            act_on  <= shd_on;
            act_off <= shd_off;
        end
    end

    // Phase counter: high for act_on cycles, then low for act_off cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            phase_hi <= 1'b1;
            cnt      <= '0;
        end else if (phase_hi) begin
            if (cnt == act_on - ONE) begin
                phase_hi <= 1'b0;
                cnt      <= '0;
            end else begin
                cnt <= cnt + ONE;
            end
        end else begin
            if (cnt == act_off - ONE) begin
                phase_hi <= 1'b1;
                cnt      <= '0;
            end else begin
                cnt <= cnt + ONE;
            end
        end
    end

    // R4
    restart_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (phase_hi && cnt == '0 && act_on == $past(shd_on) && act_off == $past(shd_off)));

    // R3
    active_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(act_on) && $stable(act_off)));

    // R2
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_on != '0 && act_off != '0) |->
        (phase_hi ? (cnt < act_on) : (cnt < act_off)));

    // R11
    wait_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (phase_hi && cnt == '0));

endmodule

// File: rtl/pwm_out_stage.sv
// Module: pwm_out_stage
// Forms the pin level from the phase, the zero-count cases, the polarity
// bit and the run gate. Pure combinational logic.
// Assumes: inputs come straight from registers.
module pwm_out_stage #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             run,
    input  logic             invert,
    input  logic [CNT_W-1:0] act_on,
    input  logic [CNT_W-1:0] act_off,
    input  logic             phase_hi,
    output logic             pwm_out
);

    logic both_zero;
    logic raw_lvl;

    // Level before polarity and gating.
    always_comb begin
        both_zero = (act_on == '0) && (act_off == '0);
        if (act_off == '0)     raw_lvl = 1'b1;
        else if (act_on == '0) raw_lvl = 1'b0;
        else                   raw_lvl = phase_hi;
    end

    // Gate and polarity.
    assign pwm_out = run && !both_zero && (raw_lvl ^ invert);

endmodule

// File: rtl/pwm_shadow_gen.sv
// Module: pwm_shadow_gen
// Top of the single-channel PWM generator with shadowed on/off counts.
// Connects the register file, the phase counter and the output stage.
// Assumes: one bus access per cycle, counts in cycles of clk.
module pwm_shadow_gen
    import pwm_shadow_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              pwm_out
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] shd_on, shd_off, act_on, act_off;
    logic             commit, phase_hi, run;

    assign run = ctrl.enable && ctrl.pin_en;

    pwm_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ctrl(ctrl), .shd_on(shd_on), .shd_off(shd_off), .commit(commit)
    );

    pwm_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .commit(commit), .run(run),
        .shd_on(shd_on), .shd_off(shd_off),
        .act_on(act_on), .act_off(act_off), .phase_hi(phase_hi)
    );

    pwm_out_stage #(.CNT_W(CNT_W)) u_out (
        .run(run), .invert(ctrl.invert), .act_on(act_on), .act_off(act_off),
        .phase_hi(phase_hi), .pwm_out(pwm_out)
    );

    // R7
    gated_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl.enable && ctrl.pin_en) |-> !pwm_out);

    // R5
    zero_pair_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_on == '0 && act_off == '0) |-> !pwm_out);

    // R6
    full_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && act_off == '0 && act_on != '0) |-> (pwm_out == !ctrl.invert));

endmodule

// File: tb/pwm_shadow_gen_tb.sv
module pwm_shadow_gen_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 50000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pwm_out;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 0;

    // Behavioural model state
    longint m_shon = 0, m_shoff = 0, m_on = 0, m_off = 0, m_pos = 0;
    bit m_en = 0, m_pe = 0, m_inv = 0;

    pwm_shadow_gen u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwm_out(pwm_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Model update on each rising edge
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_shon = 0; m_shoff = 0; m_on = 0; m_off = 0; m_pos = 0;
            m_en = 0; m_pe = 0; m_inv = 0;
        end else begin
            if (bus_sel && bus_we && bus_addr == 5'h00 && bus_wdata[5]) begin
                m_on = m_shon; m_off = m_shoff; m_pos = 0;
            end else if (m_en && m_pe && m_on != 0 && m_off != 0)
                m_pos = (m_pos + 1) % (m_on + m_off);
            else
                m_pos = 0;
            if (bus_sel && bus_we) begin
                if (bus_addr == 5'h00) begin
                    m_en = bus_wdata[0]; m_pe = bus_wdata[14]; m_inv = bus_wdata[10];
                end else if (bus_addr == 5'h18) m_shoff = bus_wdata;
                else if (bus_addr == 5'h1C) m_shon = bus_wdata;
            end
        end
    end

    function automatic bit exp_out();
        bit raw;
        if (!(m_en && m_pe)) return 0;
        if (m_on == 0 && m_off == 0) return 0;
        if (m_off == 0) raw = 1;
        else if (m_on == 0) raw = 0;
        else raw = (m_pos < m_on);
        return raw ^ m_inv;
    endfunction

    function automatic string tag_for();
        if (!rst_n) return "R1";
        if (!(m_en && m_pe)) return "R7";
        if (m_on == 0 && m_off == 0) return "R5";
        if (m_on == 0 || m_off == 0) return "R6";
        if (m_inv) return "R8";
        if (m_shon != m_on || m_shoff != m_off) return "R3";
        return "R2";
    endfunction

    // Pin compared with the model on every falling edge
    always @(negedge clk) begin
        if (!done) begin
            n_tests++;
            if (pwm_out !== exp_out()) begin
                n_fail++;
                $display("FAIL %s pwm_out at cycle %0d: actual %b expected %b",
                         tag_for(), cycles, pwm_out, exp_out());
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cycles > WD_LIMIT && !done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog expired: actual %0d cycles expected < %0d", cycles, WD_LIMIT);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0; bus_wdata = '0;
    endtask

    task automatic rd_chk(input logic [4:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        #(CLK_PERIOD/4);
        n_tests++;
        if (bus_rdata !== e) begin
            n_fail++;
            $display("FAIL %s read 0x%02h: actual 0x%08h expected 0x%08h", tag, a, bus_rdata, e);
        end
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    localparam logic [31:0] RUN_UPD = 32'h4021;
    localparam logic [31:0] RUN     = 32'h4001;
    localparam logic [31:0] RUN_INV = 32'h4401;

    initial begin
        idle(3);
        // R1: reset state
        rd_chk(5'h00, 32'h0, "R1");
        rd_chk(5'h18, 32'h0, "R1");
        rd_chk(5'h1C, 32'h0, "R1");
        rst_n = 1;
        idle(2);
        rd_chk(5'h00, 32'h0, "R1");

        // R3: shadow writes while stopped, no effect
        wr(5'h1C, 3); wr(5'h18, 2);
        rd_chk(5'h1C, 3, "R9");
        rd_chk(5'h18, 2, "R9");
        idle(4);
        // R4/R2: commit and run
        wr(5'h00, RUN_UPD);
        rd_chk(5'h00, RUN, "R9");
        idle(20);
        // R3: new shadows mid period, output keeps old pattern
        wr(5'h1C, 1); wr(5'h18, 4);
        idle(9);
        wr(5'h00, RUN_UPD);
        idle(15);
        // R8: invert without update, counter continues
        wr(5'h00, RUN_INV);
        rd_chk(5'h00, RUN_INV, "R9");
        idle(12);
        // R7: single gate bits
        wr(5'h00, 32'h0401);
        idle(4);
        wr(5'h00, 32'h4400);
        idle(4);
        // R11: re-enable without update, full period from start
        wr(5'h00, RUN);
        idle(12);
        // R5: both zero, invert set
        wr(5'h1C, 0); wr(5'h18, 0);
        wr(5'h00, RUN_INV | 32'h20);
        idle(6);
        // R6: on zero, off nonzero; normal and inverted
        wr(5'h18, 5);
        wr(5'h00, RUN_UPD);
        idle(6);
        wr(5'h00, RUN_INV);
        idle(4);
        // R6: off zero
        wr(5'h1C, 4); wr(5'h18, 0);
        wr(5'h00, RUN_UPD);
        idle(6);
        // R10: stray writes ignored, unmapped reads zero
        wr(5'h1C, 2); wr(5'h18, 3);
        wr(5'h00, RUN_UPD);
        idle(3);
        wr(5'h04, 32'hFFFF_FFFF);
        wr(5'h10, 32'hFFFF_FFFF);
        idle(4);
        rd_chk(5'h04, 32'h0, "R10");
        rd_chk(5'h10, 32'h0, "R10");
        rd_chk(5'h00, RUN, "R10");
        rd_chk(5'h1C, 2, "R10");
        rd_chk(5'h18, 3, "R10");
        // R9: all-ones control write reads back only stored bits
        wr(5'h00, 32'hFFFF_FFFF);
        rd_chk(5'h00, 32'h4401, "R9");
        idle(8);
        // R1: reset in mid run
        @(negedge clk); rst_n = 0;
        idle(2);
        @(negedge clk); rst_n = 1;
        rd_chk(5'h00, 32'h0, "R1");
        rd_chk(5'h1C, 32'h0, "R1");
        idle(4);
        // R2: longer counts
        wr(5'h1C, 7); wr(5'h18, 11);
        wr(5'h00, RUN_UPD);
        idle(60);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule